// File: doc/BRIEF.md
# Lost-Cell Dummy Block Sequencer

This block sits between a cell receive path and the writer of a per-channel reassembly buffer. It turns each received cell into an ordered run of 47-byte payload blocks. In normal operation the run is only the received payload. When the upstream sequence-number tracker is out of step and reports cells missing, the block first emits filler blocks, each made of one programmable byte, and then passes the received payload through. The writer therefore sees a gap in the stream that has the right length.

The number of filler blocks depends on a control bit. When the bit is set, the sequencer inserts the full missing-cell count, up to 7. When the bit is clear, it inserts no more than 2. The sideband inputs are the missing-cell count, the sync flag, the fill byte and the insert-all bit. They are sampled in the cycle that the first payload byte of a cell is presented. They must be held stable while that byte waits for acceptance.

Each output byte carries a block-start marker, a block-end marker and a tag that tells filler bytes apart from real ones. The input side and the output side both use a valid/ready handshake. The input side stays stalled while filler is being emitted.

Top module: `dummy_insert_seq`

## Requirements
- R1: Every output block is exactly 47 accepted bytes. `out_sob` is high on its first byte and `out_eob` is high on its last byte. Neither marker is high on any other byte.
- R2: When `in_sync` is 1 at the first byte of a cell, no filler block is emitted, whatever the value of `lost_cnt`.
- R3: When `in_sync` is 0 and `insert_all` is 1, the number of filler blocks equals `lost_cnt`. The range is 0 to 7.
- R4: When `in_sync` is 0 and `insert_all` is 0, the number of filler blocks is the smaller of `lost_cnt` and 2.
- R5: Every byte of a filler block equals the `fill_byte` value presented with the cell's first byte.
- R6: All filler blocks of a cell come before that cell's real block. The real block carries the 47 input bytes unchanged and in order. A count of 0 passes the cell straight through.
- R7: `out_dummy` is 1 on every filler byte and 0 on every real byte.
- R8: `in_ready` is 0 whenever a filler byte is offered on the output.
- R9: While `out_valid` is 1 and `out_ready` is 0, the offered byte, its markers and its tag stay unchanged until they are accepted.
- R10: After reset, `out_valid` and `in_ready` are both 0 until a cell arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_data | input | 8 | Received payload byte |
| lost_cnt | input | 3 | Missing-cell count from the sequence tracker |
| in_sync | input | 1 | Sequence tracker is in sync |
| insert_all | input | 1 | 1: insert the full count; 0: insert at most 2 |
| fill_byte | input | 8 | Byte value used for filler blocks |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_sob | output | 1 | First byte of a block |
| out_eob | output | 1 | Last byte of a block |
| out_dummy | output | 1 | Byte belongs to a filler block |

## Verification
The assertions check the following on every cycle:
- the input is stalled whenever filler is offered;
- a stalled output holds its value;
- a filler block end is followed only by a new block start;
- the byte index stays inside a block;
- the block count per cell never exceeds 7;
- the plan made at a cell's start respects the sync flag and the cap of 2.

Only the bench scenarios show the exact number of filler blocks for a given count and mode. The same holds for the fill value, and for the real payload arriving intact after the filler.

// File: rtl/dci_pkg.sv
package dci_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DUMMY = 2'd1,
    ST_PASS  = 2'd2
  } seq_state_e;

  // Number of filler blocks to place ahead of one received cell.
  function automatic int dummy_count(int lost, bit sync, bit all,
                                     int cap, int max_lost);
    int n;
    n = (lost > max_lost) ? max_lost : lost;
    if (sync)            return 0;
    if (all)             return n;
    return (n > cap) ? cap : n;
  endfunction

endpackage

// File: rtl/dci_byte_index.sv
module dci_byte_index #(
  parameter int BLOCK_BYTES = 47,
  localparam int IW = $clog2(BLOCK_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [IW-1:0] idx,
  output logic          at_first,
  output logic          at_last
);

  assign at_first = (idx == '0);
  assign at_last  = (idx == IW'(BLOCK_BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (step)    idx <= at_last ? '0 : idx + 1'b1;
  end

  // R1
  idx_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(BLOCK_BYTES - 1));

endmodule

// File: rtl/dci_cell_plan.sv
module dci_cell_plan #(
  parameter int MAX_LOST = 7,
  parameter int CAP      = 2,
  localparam int LW      = $clog2(MAX_LOST + 1)
) (
  input  logic [LW-1:0] lost,
  input  logic          sync,
  input  logic          all,
  output logic [LW-1:0] n_dummy
);

  always_comb
    n_dummy = LW'(dci_pkg::dummy_count(int'(lost), sync, all, CAP, MAX_LOST));

endmodule

// File: rtl/dummy_insert_seq.sv
module dummy_insert_seq #(
  parameter int BLOCK_BYTES = 47,
  parameter int MAX_LOST    = 7,
  parameter int CAP         = 2,
  parameter int DW          = 8,
  localparam int LW         = $clog2(MAX_LOST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [LW-1:0] lost_cnt,
  input  logic          in_sync,
  input  logic          insert_all,
  input  logic [DW-1:0] fill_byte,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sob,
  output logic          out_eob,
  output logic          out_dummy
);
  import dci_pkg::*;

  seq_state_e    state;
  logic [LW-1:0] rem;
  logic [DW-1:0] fill_q;
  logic [LW-1:0] n_dummy;
  logic [LW:0]   dummy_blocks;
  logic          at_first, at_last;

  // Named events
  logic start_evt, xfer, blk_done;
  assign start_evt = (state == ST_IDLE) && in_valid;
  assign xfer      = out_valid && out_ready;
  assign blk_done  = xfer && at_last;

  dci_cell_plan #(.MAX_LOST(MAX_LOST), .CAP(CAP)) u_plan (
    .lost(lost_cnt), .sync(in_sync), .all(insert_all), .n_dummy(n_dummy));

  dci_byte_index #(.BLOCK_BYTES(BLOCK_BYTES)) u_idx (
    .clk(clk), .rst_n(rst_n), .step(xfer),
    .idx(), .at_first(at_first), .at_last(at_last));

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_dummy = 1'b0;
    in_ready  = 1'b0;
    unique case (state)
      ST_DUMMY: begin
        out_valid = 1'b1;
        out_data  = fill_q;
        out_dummy = 1'b1;
      end
      ST_PASS: begin
        out_valid = in_valid;
        out_data  = in_data;
        in_ready  = out_ready;
      end
      default: ;
    endcase
    out_sob = out_valid && at_first;
    out_eob = out_valid && at_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      rem    <= '0;
      fill_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_evt) begin
          rem    <= n_dummy;
          fill_q <= fill_byte;
          state  <= (n_dummy == '0) ? ST_PASS : ST_DUMMY;
        end
        ST_DUMMY: if (blk_done) begin
          rem <= rem - 1'b1;
          if (rem == LW'(1)) state <= ST_PASS;
        end
        ST_PASS: if (blk_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Filler blocks emitted for the current cell
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              dummy_blocks <= '0;
    else if (blk_done && state == ST_PASS)   dummy_blocks <= '0;
    else if (blk_done && state == ST_DUMMY)  dummy_blocks <= dummy_blocks + 1'b1;
  end

  // R8
  stall_on_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dummy) |-> !in_ready);

  // R9
  hold_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && out_dummy) |=>
      (out_valid && out_dummy && $stable(out_data) && $stable(out_sob) && $stable(out_eob)));

  // R1
  sob_after_eob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && out_eob && out_dummy) |=> (!out_valid || out_sob));

  // R3
  dummy_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_blocks <= (LW+1)'(MAX_LOST));

  // R2
  sync_no_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && in_sync) |=> (state == ST_PASS));

  // R4
  cap_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !insert_all) |=> (state != ST_DUMMY || rem <= LW'(CAP)));

endmodule

// File: tb/tb_dummy_insert_seq.sv
`timescale 1ns/100ps
module tb_dummy_insert_seq;
  localparam int BLK = 47;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic [2:0] lost_cnt = '0;
  logic in_sync = 1'b0, insert_all = 1'b0;
  logic [7:0] fill_byte = '0;
  logic out_valid, out_ready = 1'b1;
  logic [7:0] out_data;
  logic out_sob, out_eob, out_dummy;

  always #2.5 clk = ~clk;

  dummy_insert_seq dut (.*);

  int errors = 0, checks = 0, cyc = 0;
  bit bp_mode = 0;

  // monitor state
  int m_idx = 0, m_dummies = 0, m_reals = 0;
  int data_err = 0, mark_err = 0, stall_err = 0, hold_err = 0, order_err = 0;
  logic [7:0] exp_fill = '0, exp_base = '0;
  bit prev_stall = 0;
  logic [7:0] prev_data; logic prev_dummy, prev_sob, prev_eob;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    out_ready = bp_mode ? (cyc % 3 != 0) : 1'b1;
  end

  always @(negedge clk) begin
    #2;
    if (prev_stall && !(out_valid && out_data == prev_data && out_dummy == prev_dummy
                        && out_sob == prev_sob && out_eob == prev_eob)) hold_err++;
    prev_stall = out_valid && !out_ready;
    prev_data = out_data; prev_dummy = out_dummy; prev_sob = out_sob; prev_eob = out_eob;
    if (out_valid && out_dummy && in_ready) stall_err++;
    if (out_valid && out_ready) begin
      if (out_sob != (m_idx == 0) || out_eob != (m_idx == BLK-1)) mark_err++;
      if (out_dummy) begin
        if (out_data != exp_fill) data_err++;
        if (m_reals != 0) order_err++;
      end else if (out_data != 8'(exp_base + m_idx)) data_err++;
      if (m_idx == BLK-1) begin
        m_idx = 0;
        if (out_dummy) m_dummies++; else m_reals++;
      end else m_idx++;
    end
  end

  task automatic send_cell(int lost, bit sync, bit all, logic [7:0] fill, logic [7:0] base);
    int sent = 0;
    bit hs;
    m_idx = 0; m_dummies = 0; m_reals = 0;
    data_err = 0; mark_err = 0; stall_err = 0; hold_err = 0; order_err = 0;
    exp_fill = fill; exp_base = base;
    @(negedge clk);
    lost_cnt = 3'(lost); in_sync = sync; insert_all = all; fill_byte = fill;
    while (sent < BLK) begin
      in_valid = 1'b1; in_data = 8'(base + sent);
      #2; hs = in_valid && in_ready;
      @(negedge clk);
      if (hs) sent++;
    end
    in_valid = 1'b0; lost_cnt = 3'(7 - lost); fill_byte = ~fill;
    repeat (6) @(negedge clk);
  endtask

  task automatic scenario(string nm, int lost, bit sync, bit all, logic [7:0] fill,
                          logic [7:0] base, string ntag);
    int exp_n;
    exp_n = sync ? 0 : (all ? lost : (lost > 2 ? 2 : lost));
    send_cell(lost, sync, all, fill, base);
    chk(m_dummies == exp_n, {ntag, " filler count ", nm}, m_dummies, exp_n);
    chk(m_reals == 1 && order_err == 0, {"R6 real block after filler ", nm}, m_reals, 1);
    chk(data_err == 0, {"R5 R6 byte values ", nm}, data_err, 0);
    chk(mark_err == 0, {"R1 R7 markers ", nm}, mark_err, 0);
    chk(stall_err == 0, {"R8 input stall ", nm}, stall_err, 0);
    chk(hold_err == 0, {"R9 hold under backpressure ", nm}, hold_err, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b0, "R10 in_ready after reset", in_ready, 0);
  endtask

  task automatic t_sync_pass();      scenario("sync", 5, 1, 1, 8'hA5, 8'h10, "R2"); endtask
  task automatic t_zero_lost();      scenario("zero", 0, 0, 1, 8'h3C, 8'h20, "R6"); endtask
  task automatic t_insert_all_max(); scenario("all7", 7, 0, 1, 8'hFF, 8'h30, "R3"); endtask
  task automatic t_insert_all_mid(); scenario("all3", 3, 0, 1, 8'h00, 8'h40, "R3"); endtask
  task automatic t_capped();         scenario("cap6", 6, 0, 0, 8'h5A, 8'h50, "R4"); endtask
  task automatic t_capped_one();     scenario("cap1", 1, 0, 0, 8'h77, 8'h60, "R4"); endtask
  task automatic t_backpressure();
    bp_mode = 1;
    scenario("bp4", 4, 0, 1, 8'hC3, 8'h70, "R3");
    scenario("bpcap", 5, 0, 0, 8'h81, 8'h80, "R4");
    bp_mode = 0;
  endtask

  initial begin
    t_reset();
    t_sync_pass();
    t_zero_lost();
    t_insert_all_max();
    t_insert_all_mid();
    t_capped();
    t_capped_one();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule